// File: doc/BRIEF.md
# Wired Interrupt Cause Controller

The block gathers 32 interrupt source lines into one wired interrupt output. Every source owns one bit of a cause register. That bit is set either while its line is high or on the line's rising edge. One control bit picks the trigger mode for all sources at once. A mask register decides which pending causes may reach the output. The output is a registered OR of all unmasked pending causes.

Software uses a single-cycle register port with address, write enable, write data and combinational read data. It reads the cause register to see which sources are pending. It acknowledges a source by writing a zero into that source's bit. Any position written with a one keeps its current value. The control register also holds a second bit, which disables message-signalled interrupt generation. That bit is only stored and read back; nothing else in the block uses it.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset, the cause register reads 0x00000000, the mask register reads 0xFFFFFFFF, the control register reads 0x00000000, and irq_o is 0.
- R2: Three offsets are decoded: cause at 0x00, mask at 0x10 and control at 0x28. Source n always maps to bit n. A read returns the current register contents in the same cycle.
- R3: In level mode (control bit 3 = 0), a cause bit is set on every clock edge at which its source is high. Clearing the bit while the source is still high has no lasting effect.
- R4: In edge mode (control bit 3 = 1), a cause bit is set only at an edge where its source is 1 and was 0 at the previous edge. A source that stays high does not set the bit again after it has been cleared.
- R5: A write to the cause register clears every bit written as 0 and leaves every bit written as 1 unchanged. Writing a 1 never sets a cause bit.
- R6: If a set event and a software clear hit the same cause bit at the same edge, the bit ends up set.
- R7: irq_o is 1 exactly when some cause bit is 1 with its mask bit 0. A mask bit of 1 blocks that source. irq_o follows the cause and mask registers one clock later.
- R8: The control register stores only bit 3 (trigger mode) and bit 5 (message interrupt disable). Every other control bit reads as 0.
- R9: Reads at any offset other than 0x00, 0x10 or 0x28 return 0. Writes to those other offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt source lines |
| addr_i | input | 8 | Register byte offset |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Wired interrupt output |

## Verification
A source change driven after edge k shows up in the cause register at edge k+1. It reaches irq_o at edge k+2. A register write done at edge k can be read back immediately after that edge. An interrupt change caused by a mask write appears after edge k+1. Each check is queued together with the edge it waits for. The monitor compares values at the falling clock edge, after the registers involved have settled. Stimulus changes one time unit after the rising edge, so the check samples can never race the clocked logic.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  parameter int unsigned NUM_SRC = 32;
  parameter int unsigned ADDR_W  = 8;

  parameter logic [ADDR_W-1:0] OFF_CAUSE = 8'h00;
  parameter logic [ADDR_W-1:0] OFF_MASK  = 8'h10;
  parameter logic [ADDR_W-1:0] OFF_CTRL  = 8'h28;

  parameter int unsigned CTRL_EDGE_BIT = 3;
  parameter int unsigned CTRL_MSID_BIT = 5;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CAUSE,
    SEL_MASK,
    SEL_CTRL
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_CAUSE: decode_off = SEL_CAUSE;
      OFF_MASK:  decode_off = SEL_MASK;
      OFF_CTRL:  decode_off = SEL_CTRL;
      default:   decode_off = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_src_detect.sv
module irq_src_detect #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         edge_mode_i,
  output logic [N-1:0] set_o
);
  logic [N-1:0] hist_q;

  for (genvar g = 0; g < N; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[g] <= 1'b0;
      else         hist_q[g] <= src_i[g];
    end
    // level: follow line; edge: 0->1 only
    assign set_o[g] = edge_mode_i ? (src_i[g] & ~hist_q[g]) : src_i[g];
  end

  // R4: a line that was already high never produces a set in edge mode
  a_r4_edge_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_mode_i |-> ((set_o & $past(src_i)) == '0));
endmodule

// File: rtl/irq_cause_regs.sv
module irq_cause_regs
  import irq_cause_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [N-1:0]  wdata_i,
  input  logic [N-1:0]  set_i,
  output logic [N-1:0]  cause_o,
  output logic [N-1:0]  mask_o,
  output logic          edge_mode_o,
  output logic [N-1:0]  rdata_o
);
  localparam logic [N-1:0] ALL_ONES = '1;

  reg_sel_e     sel;
  logic [N-1:0] cause_q, mask_q, keep_vec, ctrl_view;
  logic         edge_q, msid_q;

  assign sel = decode_off(addr_i);

  // bits written 0 are dropped; set events override
  assign keep_vec = (we_i && sel == SEL_CAUSE) ? wdata_i : ALL_ONES;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_q <= '0;
      mask_q  <= ALL_ONES;
      edge_q  <= 1'b0;
      msid_q  <= 1'b0;
    end else begin
      cause_q <= (cause_q & keep_vec) | set_i;
      if (we_i && sel == SEL_MASK) mask_q <= wdata_i;
      if (we_i && sel == SEL_CTRL) begin
        edge_q <= wdata_i[CTRL_EDGE_BIT];
        msid_q <= wdata_i[CTRL_MSID_BIT];
      end
    end
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_EDGE_BIT] = edge_q;
    ctrl_view[CTRL_MSID_BIT] = msid_q;
  end

  always_comb begin
    case (sel)
      SEL_CAUSE: rdata_o = cause_q;
      SEL_MASK:  rdata_o = mask_q;
      SEL_CTRL:  rdata_o = ctrl_view;
      default:   rdata_o = '0;
    endcase
  end

  assign cause_o     = cause_q;
  assign mask_o      = mask_q;
  assign edge_mode_o = edge_q;

  // R6: every set event lands, whatever was written
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((cause_q & $past(set_i)) == $past(set_i)));

  // R5: a cause bit only becomes 1 through a set event
  a_r5_no_write_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause_q & ~$past(cause_q) & ~$past(set_i)) == '0));

  // R9: writes to undecoded offsets leave mask and control alone
  a_r9_unmapped_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel == SEL_NONE) |=> ($stable(mask_q) && $stable(edge_q) && $stable(msid_q)));

  // R9: undecoded offsets read 0
  a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_NONE) |-> (rdata_o == '0));
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] cause_i,
  input  logic [N-1:0] mask_i,
  output logic         irq_o
);
  logic [N-1:0] live;
  logic         irq_q;

  assign live = cause_i & ~mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |live;
  end

  assign irq_o = irq_q;

  // R7: a rising output needs an unmasked cause one edge before
  a_r7_rise_needs_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past((cause_i & ~mask_i) != '0));

  // R7: fully masked inputs force the output low next cycle
  a_r7_full_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |=> !irq_o);
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int unsigned N  = NUM_SRC,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  src_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [N-1:0]  wdata_i,
  output logic [N-1:0]  rdata_o,
  output logic          irq_o
);
  logic [N-1:0] set_vec, cause, mask;
  logic         edge_mode;

  irq_src_detect #(.N(N)) u_detect (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .edge_mode_i(edge_mode),
    .set_o      (set_vec)
  );

  irq_cause_regs #(.N(N), .AW(AW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .we_i       (we_i),
    .wdata_i    (wdata_i),
    .set_i      (set_vec),
    .cause_o    (cause),
    .mask_o     (mask),
    .edge_mode_o(edge_mode),
    .rdata_o    (rdata_o)
  );

  irq_out_gen #(.N(N)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cause_i(cause),
    .mask_i (mask),
    .irq_o  (irq_o)
  );

  // R3: in level mode a high line is pending on the following cycle
  a_r3_level_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_mode && (|src_i)) |=> ((cause & $past(src_i)) == $past(src_i)));
endmodule

// File: tb/irq_cause_ctrl_test.sv
module irq_cause_ctrl_test;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  src = '0;
  logic [7:0]    addr = '0;
  logic          we = 1'b0;
  logic [N-1:0]  wdata = '0;
  logic [N-1:0]  rdata;
  logic          irq;

  always #5 clk = ~clk;

  irq_cause_ctrl uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .src_i  (src),
    .addr_i (addr),
    .we_i   (we),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  typedef struct {
    bit          is_irq;
    logic [7:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  logic  pending = 1'b0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (pending && q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? {31'b0, irq} : rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, act, it.exp);
      end
    end
  end

  task automatic chk(input bit is_irq, input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a;
    it.is_irq = is_irq; it.a = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    pending = 1'b1;
    @(negedge clk); #1;
    pending = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic drive_src(input logic [31:0] v);
    @(posedge clk); #1;
    src = v;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    chk(0, 8'h00, 32'h0000_0000, "R1 cause reset");
    chk(0, 8'h10, 32'hFFFF_FFFF, "R1 mask reset");
    chk(0, 8'h28, 32'h0000_0000, "R1 ctrl reset");
    chk(1, 8'h00, 32'h0, "R1 irq reset");

    // level mode
    drive_src(32'h0000_0005);
    chk(0, 8'h00, 32'h0000_0005, "R3 R2 level latch");
    chk(1, 8'h00, 32'h0, "R7 fully masked");
    wr(8'h10, 32'hFFFF_FFFE);
    chk(0, 8'h10, 32'hFFFF_FFFE, "R2 mask readback");
    chk(1, 8'h00, 32'h1, "R7 unmasked raises irq");
    wr(8'h00, 32'h0);
    chk(0, 8'h00, 32'h0000_0005, "R3 R6 clear while high");
    drive_src(32'h0);
    wr(8'h00, 32'h0);
    chk(0, 8'h00, 32'h0, "R3 clear after drop");
    chk(1, 8'h00, 32'h0, "R7 irq drops");

    // write-zero-to-clear
    drive_src(32'h0000_00F0);
    drive_src(32'h0);
    chk(0, 8'h00, 32'h0000_00F0, "R5 pulse latched");
    wr(8'h00, 32'hFFFF_FF7F);
    chk(0, 8'h00, 32'h0000_0070, "R5 zero bit clears");
    wr(8'h00, 32'hFFFF_FFFF);
    chk(0, 8'h00, 32'h0000_0070, "R5 ones keep");
    wr(8'h00, 32'h0000_0000);
    chk(0, 8'h00, 32'h0, "R5 zeros clear all");

    // control storage
    wr(8'h28, 32'hFFFF_FFFF);
    chk(0, 8'h28, 32'h0000_0028, "R8 only bits 3 and 5");
    wr(8'h28, 32'h0000_0020);
    chk(0, 8'h28, 32'h0000_0020, "R8 msi bit alone");
    wr(8'h28, 32'h0000_0008);
    chk(0, 8'h28, 32'h0000_0008, "R8 edge bit alone");

    // edge mode
    drive_src(32'h0000_0100);
    chk(0, 8'h00, 32'h0000_0100, "R4 rising edge latch");
    wr(8'h00, 32'h0);
    chk(0, 8'h00, 32'h0, "R4 held high no reset");
    drive_src(32'h0);
    drive_src(32'h0000_0100);
    chk(0, 8'h00, 32'h0000_0100, "R4 second edge");

    // set and clear at the same edge
    @(posedge clk); #1;
    src = 32'h0000_0200; addr = 8'h00; wdata = 32'h0; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
    chk(0, 8'h00, 32'h0000_0200, "R6 set beats clear");

    // unmapped offsets
    wr(8'h04, 32'h0);
    wr(8'h2C, 32'h0);
    wr(8'h14, 32'h0);
    chk(0, 8'h04, 32'h0, "R9 unmapped read 04");
    chk(0, 8'h14, 32'h0, "R9 unmapped read 14");
    chk(0, 8'h10, 32'hFFFF_FFFE, "R9 mask unchanged");
    chk(0, 8'h28, 32'h0000_0008, "R9 ctrl unchanged");
    chk(0, 8'h00, 32'h0000_0200, "R9 cause unchanged");

    // mask gating
    wr(8'h10, 32'hFFFF_FDFF);
    chk(1, 8'h00, 32'h1, "R7 bit9 unmasked");
    wr(8'h10, 32'hFFFF_FFFF);
    chk(1, 8'h00, 32'h0, "R7 remask");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule